// File: doc/BRIEF.md
# Multi-Width Arithmetic/Logic Unit with Flag Byte

This block performs a single arithmetic or logical operation per clock on operands that are 8, 16 or 32 bits wide. It also produces an 8-bit condition byte in which sign, zero, half-carry, overflow-or-parity, subtract and carry are each updated. A datapath feeds it two operands, an opcode, a width code and the current condition byte. One clock later it returns the result, zero-extended to 32 bits, and the new condition byte.

Eight operations are supported: add, add with incoming carry, subtract, subtract with incoming borrow, AND, OR, XOR, and a decimal adjust. The decimal adjust corrects a byte of two packed BCD digits after an earlier byte add or subtract. The nibble-carry flag is taken at a different bit for each width, always four bits below the top. A single flag bit carries signed overflow for arithmetic and carries parity for the other operations.

Top module: `mwalu`

## Requirements
- R1: While `rst_n` is low, `result` and `flags_out` are zero. Otherwise both are registered and show the operation presented at the previous rising clock edge.
- R2: Opcode 0 (add) and opcode 1 (add with carry, using `flags_in[0]` as carry-in) return the sum truncated to the width chosen by `width_sel`. Width codes are 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits, and every result bit above the chosen width is 0.
- R3: Opcode 2 (subtract) and opcode 3 (subtract with borrow, using `flags_in[0]` as borrow-in) return `src_a - src_b - borrow_in`, truncated to the chosen width.
- R4: Flag bit 0 (carry) is the carry out of the top bit of the chosen width for opcodes 0 and 1. For opcodes 2 and 3 it is the borrow.
- R5: Flag bit 4 (half carry) is the carry or borrow across bits 3/4, 11/12 or 27/28 for the 8-, 16- and 32-bit widths when an arithmetic opcode is used.
- R6: Flag bit 2 is 1 for opcodes 0 to 3 exactly when the signed result does not fit the chosen width.
- R7: Opcodes 4, 5 and 6 return the AND, OR and XOR of the operands at the chosen width. For these, and for opcode 7, flag bit 2 is 1 when the result holds an even number of ones.
- R8: Opcodes 4, 5 and 6 clear flag bits 0 and 1. Flag bit 4 is set by opcode 4 and cleared by opcodes 5 and 6.
- R9: Flag bit 1 is set by opcodes 2 and 3 and cleared by opcodes 0 and 1. Opcode 7 passes it through unchanged.
- R10: Flag bit 6 is 1 exactly when `result` is zero. Flag bit 7 equals the top bit of the result at the chosen width, or bit 7 for opcode 7.
- R11: Opcode 7 ignores `width_sel` and works on `src_a[7:0]`.
  - A correction of 0x06 applies when the low nibble exceeds 9 or `flags_in[4]` is 1.
  - A correction of 0x60 applies when the byte exceeds 0x99 or `flags_in[0]` is 1.
  - The corrections are added when `flags_in[1]` is 0 and subtracted when it is 1.
  - Flag bit 0 is 1 exactly when 0x60 was applied.
  - Flag bit 4 is the nibble carry or borrow of the correction.
- R12: Flag bits 3 and 5 of `flags_out` copy the same bits of `flags_in` for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 3 | Operation code (0 to 7, see R2 to R11) |
| width_sel | input | 2 | Operand width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand (unused by opcode 7) |
| flags_in | input | 8 | Incoming condition byte |
| result | output | 32 | Registered result, zero above the chosen width |
| flags_out | output | 8 | Registered condition byte |

## Verification
The hardest cases to reach from the ports are the nibble-carry tap at bits 27/28 of a 32-bit operation combined with carry-in or borrow-in, and the decimal adjust entered with hand-made combinations of incoming H, N and C. Random operands almost never produce the carry chains that cross these taps exactly. Directed vectors such as 0x0FFFFFFF + 1 and an all-ones add with carry-in set therefore come first. They are followed by adjust steps whose condition byte encodes a prior add or subtract, for example 0x9A with nothing set and 0x2D with N and H set. After those, a long random phase covers every opcode and width code, including the reserved width code 3.

// File: rtl/mwalu_pkg.sv
package mwalu_pkg;

   typedef enum logic [2:0] {
      ALU_ADD  = 3'd0,
      ALU_ADC  = 3'd1,
      ALU_SUB  = 3'd2,
      ALU_SBC  = 3'd3,
      ALU_AND  = 3'd4,
      ALU_OR   = 3'd5,
      ALU_XOR  = 3'd6,
      ALU_DADJ = 3'd7
   } alu_op_e;

   localparam int FLG_C  = 0;
   localparam int FLG_N  = 1;
   localparam int FLG_PV = 2;
   localparam int FLG_X3 = 3;
   localparam int FLG_H  = 4;
   localparam int FLG_X5 = 5;
   localparam int FLG_Z  = 6;
   localparam int FLG_S  = 7;

endpackage

// File: rtl/mwalu_addsub.sv
module mwalu_addsub #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic              do_sub,
   input  logic              carry_in,
   output logic [LANE_W-1:0] sum,
   output logic              carry_out,
   output logic              nib_carry,
   output logic              sgn_ovf
);
   localparam int TAP = LANE_W - 4;

   logic [LANE_W:0] ext;

   always_comb begin
      if (do_sub)
         ext = {1'b0, a} - {1'b0, b} - (LANE_W+1)'(carry_in);
      else
         ext = {1'b0, a} + {1'b0, b} + (LANE_W+1)'(carry_in);
   end

   assign sum       = ext[LANE_W-1:0];
   assign carry_out = ext[LANE_W];
   assign nib_carry = a[TAP] ^ b[TAP] ^ ext[TAP];
   assign sgn_ovf   = do_sub ? ((a[LANE_W-1] != b[LANE_W-1]) && (ext[LANE_W-1] != a[LANE_W-1]))
                             : ((a[LANE_W-1] == b[LANE_W-1]) && (ext[LANE_W-1] != a[LANE_W-1]));
endmodule

// File: rtl/mwalu_logic.sv
module mwalu_logic
   import mwalu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         default: y = a ^ b;
      endcase
   end
endmodule

// File: rtl/mwalu_decadj.sv
module mwalu_decadj (
   input  logic [7:0] val,
   input  logic       was_sub,
   input  logic       half_in,
   input  logic       carry_in,
   output logic [7:0] adj,
   output logic       carry_out,
   output logic       half_out
);
   logic       fix_lo;
   logic       fix_hi;
   logic [7:0] corr;

   assign fix_lo    = (val[3:0] > 4'd9) | half_in;
   assign fix_hi    = (val > 8'h99) | carry_in;
   assign corr      = {1'b0, fix_hi, fix_hi, 2'b00, fix_lo, fix_lo, 1'b0};
   assign adj       = was_sub ? (val - corr) : (val + corr);
   assign carry_out = fix_hi;
   assign half_out  = val[4] ^ adj[4];
endmodule

// File: rtl/mwalu.sv
module mwalu
   import mwalu_pkg::*;
#(
   parameter int BASE_W     = 8,
   parameter int NUM_WIDTHS = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  opcode,
   input  logic [1:0]  width_sel,
   input  logic [31:0] src_a,
   input  logic [31:0] src_b,
   input  logic [7:0]  flags_in,
   output logic [31:0] result,
   output logic [7:0]  flags_out
);
   localparam int DATA_W = BASE_W << (NUM_WIDTHS - 1);

   if (BASE_W < 8) begin : g_bad_base
      $error("mwalu: BASE_W must be at least 8");
   end
   if (NUM_WIDTHS < 1 || NUM_WIDTHS > 4) begin : g_bad_count
      $error("mwalu: NUM_WIDTHS must lie in 1..4");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("mwalu: widest lane must equal the 32-bit port width");
   end

   alu_op_e op;
   assign op = alu_op_e'(opcode);

   logic [1:0] lane;
   assign lane = (32'(width_sel) >= NUM_WIDTHS) ? 2'(NUM_WIDTHS - 1) : width_sel;

   logic [DATA_W-1:0] lane_sum  [NUM_WIDTHS];
   logic [DATA_W-1:0] lane_mask [NUM_WIDTHS];
   logic [NUM_WIDTHS-1:0] lane_c, lane_h, lane_v;
   logic is_sub, cin;

   assign is_sub = (op == ALU_SUB) || (op == ALU_SBC);
   assign cin    = ((op == ALU_ADC) || (op == ALU_SBC)) ? flags_in[FLG_C] : 1'b0;

   for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_lane
      localparam int LW = BASE_W << k;
      logic [LW-1:0] s;
      mwalu_addsub #(.LANE_W(LW)) u_as (
         .a         (src_a[LW-1:0]),
         .b         (src_b[LW-1:0]),
         .do_sub    (is_sub),
         .carry_in  (cin),
         .sum       (s),
         .carry_out (lane_c[k]),
         .nib_carry (lane_h[k]),
         .sgn_ovf   (lane_v[k])
      );
      if (LW == DATA_W) begin : g_full
         assign lane_sum[k] = s;
      end else begin : g_part
         assign lane_sum[k] = {{(DATA_W-LW){1'b0}}, s};
      end
      assign lane_mask[k] = {DATA_W{1'b1}} >> (DATA_W - LW);
   end

   logic [DATA_W-1:0] logic_y;
   mwalu_logic #(.DATA_W(DATA_W)) u_logic (
      .op (op),
      .a  (src_a),
      .b  (src_b),
      .y  (logic_y)
   );

   logic [7:0] dadj_y;
   logic       dadj_c, dadj_h;
   mwalu_decadj u_dadj (
      .val       (src_a[7:0]),
      .was_sub   (flags_in[FLG_N]),
      .half_in   (flags_in[FLG_H]),
      .carry_in  (flags_in[FLG_C]),
      .adj       (dadj_y),
      .carry_out (dadj_c),
      .half_out  (dadj_h)
   );

   logic [DATA_W-1:0] res_d;
   logic c_d, n_d, h_d, pv_d, s_d;

   always_comb begin
      res_d = '0;
      c_d   = 1'b0;
      n_d   = 1'b0;
      h_d   = 1'b0;
      pv_d  = 1'b0;
      unique case (op)
         ALU_ADD, ALU_ADC, ALU_SUB, ALU_SBC: begin
            res_d = lane_sum[lane];
            c_d   = lane_c[lane];
            h_d   = lane_h[lane];
            pv_d  = lane_v[lane];
            n_d   = is_sub;
         end
         ALU_AND, ALU_OR, ALU_XOR: begin
            res_d = logic_y & lane_mask[lane];
            h_d   = (op == ALU_AND);
            pv_d  = ~^(logic_y & lane_mask[lane]);
         end
         default: begin
            res_d = {{(DATA_W-8){1'b0}}, dadj_y};
            c_d   = dadj_c;
            h_d   = dadj_h;
            n_d   = flags_in[FLG_N];
            pv_d  = ~^dadj_y;
         end
      endcase
   end

   always_comb begin
      if (op == ALU_DADJ)
         s_d = dadj_y[7];
      else
         s_d = |(res_d & ~(lane_mask[lane] >> 1));
   end

   logic unused_flags;
   assign unused_flags = ^{flags_in[FLG_S], flags_in[FLG_Z], flags_in[FLG_PV]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         flags_out <= '0;
      end else begin
         result    <= res_d;
         flags_out <= {s_d, (res_d == '0), flags_in[FLG_X5], h_d,
                       flags_in[FLG_X3], pv_d, n_d, c_d};
      end
   end
endmodule

// File: rtl/mwalu_chk.sv
module mwalu_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  opcode,
   input logic [1:0]  width_sel,
   input logic [7:0]  flags_in,
   input logic [31:0] result,
   input logic [7:0]  flags_out
);
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assert_undef_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (flags_out[5] == $past(flags_in[5])) && (flags_out[3] == $past(flags_in[3])));

   assert_logic_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && ($past(opcode) >= 3'd4) && ($past(opcode) <= 3'd6))
      |-> (!flags_out[0] && !flags_out[1] && (flags_out[4] == ($past(opcode) == 3'd4))));

   assert_sub_sets_n_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && ($past(opcode) <= 3'd3)) |-> (flags_out[1] == $past(opcode[1])));

   assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (flags_out[6] == (result == 32'd0)));

   assert_byte_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (($past(width_sel) == 2'd0) || ($past(opcode) == 3'd7)))
      |-> (result[31:8] == 24'd0));

   assert_dadj_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && ($past(opcode) == 3'd7) && $past(flags_in[0])) |-> flags_out[0]);
endmodule

bind mwalu mwalu_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .opcode    (opcode),
   .width_sel (width_sel),
   .flags_in  (flags_in),
   .result    (result),
   .flags_out (flags_out)
);

// File: tb/mwalu_test.sv
`timescale 1ns/1ps
module mwalu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  opcode = '0;
   logic [1:0]  width_sel = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [7:0]  flags_in = '0;
   logic [31:0] result;
   logic [7:0]  flags_out;

   int checks = 0;
   int errors = 0;

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] res;
      logic [7:0]  flg;
   } exp_t;
   exp_t pend[$];

   always #2.5 clk = ~clk;

   mwalu uut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .width_sel(width_sel),
      .src_a(src_a), .src_b(src_b), .flags_in(flags_in),
      .result(result), .flags_out(flags_out)
   );

   initial begin
      #(5ns * 150000);
      errors++;
      $display("FAIL watchdog R1: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic void model(input logic [2:0] op, input logic [1:0] ws,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [7:0] f, output exp_t e);
      longint w, mask, hm, half, aa, bb, cin, s, sa, sb, exact, r;
      logic c, n, h, pv, z, sg;
      w    = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
      mask = (longint'(1) << w) - 1;
      hm   = (longint'(1) << (w - 4)) - 1;
      half = longint'(1) << (w - 1);
      aa   = longint'(a) & mask;
      bb   = longint'(b) & mask;
      cin  = (op == 3'd1 || op == 3'd3) ? longint'(f[0]) : 0;
      c = 0; n = 0; h = 0; pv = 0; r = 0;
      if (op <= 3'd3) begin
         sa = (aa >= half) ? aa - (longint'(1) << w) : aa;
         sb = (bb >= half) ? bb - (longint'(1) << w) : bb;
         if (op >= 3'd2) begin
            s = aa - bb - cin;  c = (s < 0);  n = 1;
            h = (((aa & hm) - (bb & hm) - cin) < 0);
            exact = sa - sb - cin;
         end else begin
            s = aa + bb + cin;  c = ((s >> w) & 1) != 0;
            h = ((((aa & hm) + (bb & hm) + cin) >> (w - 4)) & 1) != 0;
            exact = sa + sb + cin;
         end
         r  = s & mask;
         pv = (exact > half - 1) || (exact < -half);
      end else if (op <= 3'd6) begin
         if (op == 3'd4) r = aa & bb;
         else if (op == 3'd5) r = aa | bb;
         else r = aa ^ bb;
         h  = (op == 3'd4);
         pv = ($countones(r[31:0]) % 2) == 0;
      end else begin
         longint v, corr, lo;
         logic fl, fh;
         w  = 8;
         v  = longint'(a[7:0]);
         lo = v % 16;
         fl = (lo > 9) || f[4];
         fh = (v > 153) || f[0];
         corr = (fl ? 6 : 0) + (fh ? 96 : 0);
         n = f[1];
         r = (n ? v - corr : v + corr) & 255;
         h = n ? ((lo - (fl ? 6 : 0)) < 0) : ((lo + (fl ? 6 : 0)) > 15);
         c = fh;
         pv = ($countones(r[31:0]) % 2) == 0;
      end
      z  = (r == 0);
      sg = ((r >> (w - 1)) & 1) != 0;
      e.op  = op;
      e.res = r[31:0];
      e.flg = {sg, z, f[5], h, f[3], pv, n, c};
   endfunction

   function automatic string res_tag(input logic [2:0] op);
      if (op <= 3'd1) return "R2";
      if (op <= 3'd3) return "R3";
      if (op <= 3'd6) return "R7";
      return "R11";
   endfunction

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic check_pending();
      exp_t e;
      if (pend.size() == 0) return;
      e = pend.pop_front();
      cmp({res_tag(e.op), " result"}, result, e.res);
      cmp((e.op == 3'd7) ? "R11 carry" : (e.op >= 3'd4) ? "R8 carry" : "R4 carry",
          32'(flags_out[0]), 32'(e.flg[0]));
      cmp((e.op >= 3'd4 && e.op <= 3'd6) ? "R8 subtract" : "R9 subtract",
          32'(flags_out[1]), 32'(e.flg[1]));
      cmp((e.op <= 3'd3) ? "R6 overflow" : "R7 parity", 32'(flags_out[2]), 32'(e.flg[2]));
      cmp((e.op == 3'd7) ? "R11 half" : (e.op >= 3'd4) ? "R8 half" : "R5 half",
          32'(flags_out[4]), 32'(e.flg[4]));
      cmp("R10 zero/sign", 32'(flags_out[7:6]), 32'(e.flg[7:6]));
      cmp("R12 spare bits", 32'({flags_out[5], flags_out[3]}), 32'({e.flg[5], e.flg[3]}));
   endtask

   task automatic step(input logic [2:0] op, input logic [1:0] ws,
                       input logic [31:0] a, input logic [31:0] b, input logic [7:0] f);
      exp_t e;
      @(negedge clk);
      check_pending();
      opcode = op; width_sel = ws; src_a = a; src_b = b; flags_in = f;
      model(op, ws, a, b, f, e);
      pend.push_back(e);
   endtask

   initial begin
      opcode = 3'd1; width_sel = 2'd2; src_a = 32'hFFFF_FFFF; src_b = 32'h1; flags_in = 8'hFF;
      repeat (3) begin
         @(negedge clk);
         cmp("R1 reset result", result, 32'h0);
         cmp("R1 reset flags", 32'(flags_out), 32'h0);
      end
      rst_n = 1'b1;

      step(3'd0, 2'd0, 32'h7F, 32'h01, 8'h00);
      step(3'd0, 2'd0, 32'hFF, 32'h01, 8'h28);
      step(3'd0, 2'd1, 32'h0FFF, 32'h0001, 8'h00);
      step(3'd0, 2'd2, 32'h0FFF_FFFF, 32'h1, 8'h00);
      step(3'd1, 2'd2, 32'hFFFF_FFFF, 32'h0, 8'h01);
      step(3'd1, 2'd3, 32'h7FFF_FFFF, 32'h0, 8'h01);
      step(3'd2, 2'd0, 32'h00, 32'h01, 8'h00);
      step(3'd3, 2'd1, 32'h8000, 32'h0000, 8'h01);
      step(3'd2, 2'd2, 32'h5, 32'h5, 8'h08);
      step(3'd3, 2'd2, 32'h1000_0000, 32'h0, 8'h01);
      step(3'd4, 2'd0, 32'hABCD_12F0, 32'h3C, 8'h13);
      step(3'd5, 2'd1, 32'h1234_0F00, 32'h00F1, 8'h11);
      step(3'd6, 2'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'h03);
      step(3'd7, 2'd2, 32'hFFFF_FF3C, 32'h0, 8'h00);
      step(3'd7, 2'd0, 32'h9A, 32'h0, 8'h00);
      step(3'd7, 2'd1, 32'h2D, 32'h0, 8'h12);
      step(3'd7, 2'd0, 32'h05, 32'h0, 8'h11);
      step(3'd7, 2'd0, 32'h00, 32'h0, 8'h13);

      for (int i = 0; i < 4000; i++)
         step(3'($urandom), 2'($urandom), $urandom, $urandom, 8'($urandom));

      @(negedge clk);
      check_pending();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule